// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 64-word by 36-bit first-in first-out buffer between two unrelated clock domains. The producer side pushes words on its own clock with a write enable. The consumer side pops words on a second, independent clock, and each popped word appears on a registered output. Each side sees two status flags that are computed in its own clock domain. The producer sees full and almost-full. The consumer sees empty and almost-empty.

The almost thresholds come from one offset value, X. Both domains load X from a 2-bit selector, on the clock edges of each domain that occur while that domain's reset is held low. The same offset sets both thresholds: almost-empty is low at X words or fewer, and almost-full is low at 64-X words or more.

Pointers cross between the domains in Gray code through two-flop synchronizers. When the far side moves its pointer, a local flag is released on the second rising edge of the local clock.

Top module: `dual_clk_fifo`

## Requirements
- R1: Accepted words leave in the order they were accepted, up to 64 words held. rdata_o updates on the read-clock edge that accepts a read.
- R2: A write presented while full_no is low is ignored. No word is stored and the write pointer does not advance.
- R3: A read presented while empty_no is low is ignored. The read pointer does not advance and rdata_o keeps its value.
- R4: full_no is low when 64 words are held. After a read at 64 words, full_no returns high on the second rising write-clock edge after the read edge.
- R5: empty_no is low when 0 words are held. After a write into an empty buffer, empty_no goes high on the second rising read-clock edge after the write edge.
- R6: aempty_no is low when X or fewer words are held and high when X+1 or more are held. aempty_no is never high while empty_no is low.
- R7: afull_no is low when 64-X or more words are held and high when 63-X or fewer are held. afull_no is never high while full_no is low.
- R8: X is 16, 12, 8 or 4 for xsel_i values 0, 1, 2 and 3. Each domain samples xsel_i on its clock edges while its reset is low. Changing xsel_i after reset has no effect.
- R9: After reset, empty_no=0, aempty_no=0, afull_no=1, full_no=1 and rdata_o=0.
- R10: The Gray-coded pointers sent across domains change by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| wrst_ni | input | 1 | Write-side asynchronous reset, active low |
| rclk_i | input | 1 | Read-side clock |
| rrst_ni | input | 1 | Read-side asynchronous reset, active low |
| xsel_i | input | 2 | Offset preset selector, sampled during reset |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | 36 | Write data |
| full_no | output | 1 | Full flag, active low, write clock |
| afull_no | output | 1 | Almost-full flag, active low, write clock |
| rd_en_i | input | 1 | Read request |
| rdata_o | output | 36 | Registered read data |
| empty_no | output | 1 | Empty flag, active low, read clock |
| aempty_no | output | 1 | Almost-empty flag, active low, read clock |

## Verification
The hardest situation to reach is the exact moment a flag is released after a pointer move in the far domain, because the two clocks drift against each other. The stimulus uses clock periods whose edges can never coincide. It moves the far pointer by exactly one word and then counts the rising edges of the local clock, checking the flag just after the first and just after the second. Boundary fills at 64-X, X and X+1 are reached by counted bursts. This is done once with the default offset and once after a reset with the smallest preset, with the selector changed after reset to show that it is ignored.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned PRESET_BASE = 16;
  localparam int unsigned PRESET_STEP = 4;

  // xsel 0..3 -> 16,12,8,4
  function automatic int unsigned preset_offset(input logic [1:0] sel);
    return PRESET_BASE - PRESET_STEP * int'(sel);
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge wclk_i) begin
    if (we_i) ram_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni)  rdata_q <= '0;
    else if (re_i) rdata_q <= ram_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       xsel_i,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] rgray_sync_i,
  output logic             wr_go_o,
  output logic [PTR_W-1:0] wbin_o,
  output logic [PTR_W-1:0] wgray_o,
  output logic [ADDR_W-1:0] off_o,
  output logic             full_no,
  output logic             afull_no
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] off_q;
  logic [PTR_W-1:0]  wbin_q, wgray_q, wbin_nxt, rbin_sync, fill;

  // offset loads on clock edges while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) off_q <= ADDR_W'(preset_offset(xsel_i));
  end

  always_comb begin
    rbin_sync[PTR_W-1] = rgray_sync_i[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) rbin_sync[i] = rbin_sync[i+1] ^ rgray_sync_i[i];
  end

  assign fill     = wbin_q - rbin_sync;
  assign full_no  = (fill != PTR_W'(DEPTH));
  assign afull_no = (fill < (PTR_W'(DEPTH) - {1'b0, off_q}));
  assign wr_go_o  = wr_en_i && full_no;
  assign wbin_nxt = wbin_q + PTR_W'(wr_go_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;
  assign off_o   = off_q;
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       xsel_i,
  input  logic             rd_en_i,
  input  logic [PTR_W-1:0] wgray_sync_i,
  output logic             rd_go_o,
  output logic [PTR_W-1:0] rbin_o,
  output logic [PTR_W-1:0] rgray_o,
  output logic             empty_no,
  output logic             aempty_no
);
  logic [ADDR_W-1:0] off_q;
  logic [PTR_W-1:0]  rbin_q, rgray_q, rbin_nxt, wbin_sync, fill;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) off_q <= ADDR_W'(preset_offset(xsel_i));
  end

  always_comb begin
    wbin_sync[PTR_W-1] = wgray_sync_i[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) wbin_sync[i] = wbin_sync[i+1] ^ wgray_sync_i[i];
  end

  assign fill      = wbin_sync - rbin_q;
  assign empty_no  = (fill != '0);
  assign aempty_no = (fill > {1'b0, off_q});
  assign rd_go_o   = rd_en_i && empty_no;
  assign rbin_nxt  = rbin_q + PTR_W'(rd_go_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  assign rbin_o  = rbin_q;
  assign rgray_o = rgray_q;
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic [1:0]        xsel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_no,
  output logic              afull_no,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_no,
  output logic              aempty_no
);
  localparam int unsigned PTR_W = ADDR_W + 1;

  logic              w_go, r_go;
  logic [PTR_W-1:0]  w_bin, w_gray, r_bin, r_gray, wgray_at_r, rgray_at_w;
  logic [ADDR_W-1:0] w_off;

  dcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rrst_ni), .d_i(w_gray), .q_o(wgray_at_r)
  );

  dcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .d_i(r_gray), .q_o(rgray_at_w)
  );

  dcf_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .xsel_i(xsel_i), .wr_en_i(wr_en_i),
    .rgray_sync_i(rgray_at_w), .wr_go_o(w_go), .wbin_o(w_bin), .wgray_o(w_gray),
    .off_o(w_off), .full_no(full_no), .afull_no(afull_no)
  );

  dcf_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i(rclk_i), .rst_ni(rrst_ni), .xsel_i(xsel_i), .rd_en_i(rd_en_i),
    .wgray_sync_i(wgray_at_r), .rd_go_o(r_go), .rbin_o(r_bin), .rgray_o(r_gray),
    .empty_no(empty_no), .aempty_no(aempty_no)
  );

  dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk_i(wclk_i), .we_i(w_go), .waddr_i(w_bin[ADDR_W-1:0]), .wdata_i(wdata_i),
    .rclk_i(rclk_i), .rrst_ni(rrst_ni), .re_i(r_go), .raddr_i(r_bin[ADDR_W-1:0]),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input logic              wclk_i,
  input logic              wrst_ni,
  input logic              rclk_i,
  input logic              rrst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              full_no,
  input logic              afull_no,
  input logic              empty_no,
  input logic              aempty_no,
  input logic [DATA_W-1:0] rdata_o,
  input logic [PTR_W-1:0]  w_bin,
  input logic [PTR_W-1:0]  r_bin,
  input logic [PTR_W-1:0]  w_gray,
  input logic [PTR_W-1:0]  r_gray,
  input logic [ADDR_W-1:0] w_off
);
  assert_no_overflow_R2: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (wr_en_i && !full_no) |=> $stable(w_bin));

  assert_no_underflow_R3: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (rd_en_i && !empty_no) |=> ($stable(r_bin) && $stable(rdata_o)));

  assert_empty_implies_aempty_R6: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !empty_no |-> !aempty_no);

  assert_full_implies_afull_R7: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    !full_no |-> !afull_no);

  assert_offset_held_R8: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    wrst_ni |=> $stable(w_off));

  assert_wgray_step_R10: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (w_gray != $past(w_gray)) |-> ($countones(w_gray ^ $past(w_gray)) == 1));

  assert_rgray_step_R10: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (r_gray != $past(r_gray)) |-> ($countones(r_gray ^ $past(r_gray)) == 1));
endmodule

bind dual_clk_fifo dcf_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk_i(wclk_i), .wrst_ni(wrst_ni), .rclk_i(rclk_i), .rrst_ni(rrst_ni),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .full_no(full_no), .afull_no(afull_no),
  .empty_no(empty_no), .aempty_no(aempty_no), .rdata_o(rdata_o),
  .w_bin(w_bin), .r_bin(r_bin), .w_gray(w_gray), .r_gray(r_gray), .w_off(w_off)
);

// File: tb/sim_dual_clk_fifo.sv
module sim_dual_clk_fifo;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int NVEC = 10;
  // {writes[7:0], reads[7:0], {empty_no, aempty_no, afull_no, full_no}}, X=16
  localparam logic [19:0] VEC [NVEC] = '{
    {8'd1,  8'd0,  4'b1011},  // 1
    {8'd16, 8'd0,  4'b1111},  // 17
    {8'd0,  8'd1,  4'b1011},  // 16
    {8'd31, 8'd0,  4'b1111},  // 47
    {8'd1,  8'd0,  4'b1101},  // 48
    {8'd16, 8'd0,  4'b1100},  // 64
    {8'd1,  8'd0,  4'b1100},  // write at full ignored
    {8'd0,  8'd1,  4'b1101},  // 63
    {8'd0,  8'd63, 4'b0011},  // 0
    {8'd0,  8'd1,  4'b0011}   // read at empty ignored
  };

  logic        wclk, rclk, wrst_n, rrst_n, wr_en, rd_en;
  logic [1:0]  xsel;
  logic [35:0] wdata, rdata;
  logic        full_n, afull_n, empty_n, aempty_n;

  int n_chk, n_bad, seq;
  logic [35:0] q_model [$];
  logic [35:0] last_rd;

  dual_clk_fifo u0 (
    .wclk_i(wclk), .wrst_ni(wrst_n), .rclk_i(rclk), .rrst_ni(rrst_n), .xsel_i(xsel),
    .wr_en_i(wr_en), .wdata_i(wdata), .full_no(full_n), .afull_no(afull_n),
    .rd_en_i(rd_en), .rdata_o(rdata), .empty_no(empty_n), .aempty_no(aempty_n)
  );

  // write edges at odd times, read edges at even times: never coincident
  initial begin
    wclk = 0;
    forever #(CLK_PERIOD/2) wclk = ~wclk;
  end
  initial begin
    rclk = 0;
    #2;
    forever begin
      rclk = 1; #(RCLK_PERIOD/2);
      rclk = 0; #(RCLK_PERIOD/2);
    end
  end

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge wclk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_up();
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  function automatic logic [35:0] mk(input int s);
    return {4'(s * 7), 32'(s) * 32'h9E3779B9};
  endfunction

  task automatic do_reset(input logic [1:0] sel);
    wr_en = 0; rd_en = 0; xsel = sel; wrst_n = 0; rrst_n = 0;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk) wrst_n = 1;
    @(negedge rclk) rrst_n = 1;
    q_model.delete();
    last_rd = '0;
  endtask

  task automatic settle();
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en = 1;
      wdata = mk(seq);
      seq++;
      if (full_n) q_model.push_back(wdata);
    end
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic read_n(input int n);
    logic pend = 0;
    logic [35:0] exp_d = '0;
    for (int i = 0; i < n + 1; i++) begin
      @(negedge rclk);
      if (i > 0) begin
        if (pend) begin
          chk("R1 data order", 64'(rdata), 64'(exp_d));
          last_rd = exp_d;
        end else begin
          chk("R3 ignored read holds rdata_o", 64'(rdata), 64'(last_rd));
        end
      end
      if (i < n) begin
        rd_en = 1;
        pend = empty_n;
        if (pend) exp_d = q_model.pop_front();
      end else begin
        rd_en = 0;
      end
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; seq = 1;
    wdata = '0;
    do_reset(2'd0);
    settle();
    chk("R9 reset flags", 64'({empty_n, aempty_n, afull_n, full_n}), 64'(4'b0011));
    chk("R9 reset rdata_o", 64'(rdata), 64'h0);

    // table walk, X=16
    for (int v = 0; v < NVEC; v++) begin
      write_n(int'(VEC[v][19:12]));
      read_n(int'(VEC[v][11:4]));
      settle();
      chk($sformatf("R2 R4 R5 R6 R7 vector %0d flags", v),
          64'({empty_n, aempty_n, afull_n, full_n}), 64'(VEC[v][3:0]));
    end
    chk("R1 model drained", 64'(q_model.size()), 64'h0);

    // R5: empty released on second read edge after a write
    @(negedge wclk);
    wr_en = 1; wdata = mk(seq); seq++;
    q_model.push_back(wdata);
    @(posedge wclk);
    wr_en <= 0;
    @(posedge rclk); #1;
    chk("R5 empty_no after first read edge", 64'(empty_n), 64'h0);
    @(posedge rclk); #1;
    chk("R5 empty_no after second read edge", 64'(empty_n), 64'h1);
    read_n(1);

    // R4: full released on second write edge after a read
    write_n(64);
    settle();
    chk("R4 full_no at 64", 64'(full_n), 64'h0);
    @(negedge rclk);
    rd_en = 1;
    last_rd = q_model.pop_front();
    @(posedge rclk);
    rd_en <= 0;
    @(posedge wclk); #1;
    chk("R4 full_no after first write edge", 64'(full_n), 64'h0);
    @(posedge wclk); #1;
    chk("R4 full_no after second write edge", 64'(full_n), 64'h1);
    chk("R7 afull_no at 63", 64'(afull_n), 64'h0);
    chk("R1 rdata_o first word", 64'(rdata), 64'(last_rd));
    read_n(63);
    settle();
    chk("R5 empty after drain", 64'(empty_n), 64'h0);

    // R8: smallest preset X=4, selector changed after reset
    do_reset(2'd3);
    xsel = 2'd0;
    write_n(4);
    settle();
    chk("R6 R8 aempty_no at X=4 words", 64'(aempty_n), 64'h0);
    write_n(1);
    settle();
    chk("R6 R8 aempty_no at X+1 words", 64'(aempty_n), 64'h1);
    write_n(54);
    settle();
    chk("R7 R8 afull_no at 59 words", 64'(afull_n), 64'h1);
    write_n(1);
    settle();
    chk("R7 R8 afull_no at 60 words", 64'(afull_n), 64'h0);
    chk("R4 full_no at 60 words", 64'(full_n), 64'h1);
    read_n(60);
    settle();
    chk("R5 R6 flags after drain", 64'({empty_n, aempty_n}), 64'h0);

    finish_up();
  end
endmodule